// File: doc/BRIEF.md
# Network Interrupt Packet Receiver

This block sits at a node of a shared-memory ring, behind the link decoder. It looks at every decoded packet and picks out the interrupt packets that are meant for this node. A packet is meant for this node when its destination matches the node's own identifier or carries the all-nodes code. Each accepted packet leaves one entry in a queue for its interrupt level. The entry holds the sender's node identifier and the packet's 32-bit word, which software usually treats as a vector.

There are four levels, and each has its own queue. A level's interrupt line stays high while its queue holds at least one entry and software has enabled that level. The host drains a queue one entry per read request, and the entry comes back on the cycle after the request. Once the queue is empty, the interrupt line drops. If a packet arrives while its queue is full, the packet is discarded and a sticky per-level overflow flag is set. The host clears that flag with a clear strobe.

Top module: `nirq_rx`

## Requirements
- R1: A packet is taken only in a cycle where both `pkt_valid` and `pkt_cmd` are 1. If either is 0, no queue changes.
- R2: A packet whose `pkt_dst` differs from `node_id` and is not 8'hFF is ignored.
- R3: A packet with `pkt_dst` = 8'hFF is accepted at every node, whatever `node_id` is.
- R4: An accepted packet is appended to the queue chosen by `pkt_level` (0 to 3). Each queue returns its entries in arrival order.
- R5: `irq[n]` is 1 exactly when `irq_en[n]` is 1 and queue n is not empty. It follows the state of the previous clock edge.
- R6: `host_rd` with `host_level` = n pops queue n when that queue is not empty. On the next cycle, `rd_valid` is 1 and `rd_src`/`rd_data` hold the popped sender ID and word. A read of an empty queue leaves `rd_valid` at 0 and changes nothing.
- R7: A packet accepted for a full queue is dropped and sets `ovf[n]`. The flag stays set until `ovf_clr[n]` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R8: Each queue holds DEPTH entries (default 127). All of them are kept and read back intact.
- R9: After reset, every queue is empty, and `irq`, `ovf` and `rd_valid` are 0.
- R10: Traffic on one level does not change the contents or order of any other level's queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | Static identifier of this node |
| pkt_valid | input | 1 | Decoded packet present this cycle |
| pkt_cmd | input | 1 | Command strobe marking an interrupt packet |
| pkt_level | input | 2 | Interrupt level of the packet |
| pkt_src | input | 8 | Sender node identifier |
| pkt_dst | input | 8 | Destination node identifier, 8'hFF for all nodes |
| pkt_data | input | 32 | Vector word of the packet |
| irq_en | input | 4 | Per-level interrupt enable |
| host_rd | input | 1 | Host pop request |
| host_level | input | 2 | Level queue to pop |
| ovf_clr | input | 4 | Per-level overflow clear strobe |
| rd_valid | output | 1 | Popped entry present on rd_src/rd_data |
| rd_src | output | 8 | Sender ID of popped entry |
| rd_data | output | 32 | Vector word of popped entry |
| irq | output | 4 | Per-level interrupt lines |
| ovf | output | 4 | Sticky per-level overflow flags |

## Verification
The address filter is exercised with packets aimed at the local identifier, at a neighbouring identifier and at the all-nodes code. Further packets with the strobe or the valid bit withheld show that the filter checks all three conditions and not just the address. Packets interleaved across levels show that each queue keeps its own order and is not disturbed by traffic on other levels. One queue is filled to exactly its depth and then sent one more packet. This separates the last entry that is kept from the first one dropped, and the full drain proves that the earlier entries were not overwritten. The enable bit is toggled with a non-empty queue to show that the interrupt depends on both the enable and the queue state.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    localparam int NODE_W = 8;
    localparam int DATA_W = 32;
    localparam int LEVELS = 4;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam logic [NODE_W-1:0] ALL_NODES = 8'hFF;

    typedef struct packed {
        logic              valid;
        logic              cmd;
        logic [LVL_W-1:0]  level;
        logic [NODE_W-1:0] src;
        logic [NODE_W-1:0] dst;
        logic [DATA_W-1:0] data;
    } pkt_t;

    typedef struct packed {
        logic [NODE_W-1:0] src;
        logic [DATA_W-1:0] data;
    } entry_t;

    function automatic logic addressed_to(input logic [NODE_W-1:0] dst,
                                          input logic [NODE_W-1:0] self);
        return (dst == self) || (dst == ALL_NODES);
    endfunction
endpackage

// File: rtl/nirq_match.sv
module nirq_match
    import nirq_pkg::*;
(
    input  pkt_t              pkt,
    input  logic [NODE_W-1:0] node_id,
    output logic [LEVELS-1:0] push,
    output entry_t            entry
);
    logic take;

    always_comb begin
        take = pkt.valid && pkt.cmd && addressed_to(pkt.dst, node_id);
        entry.src  = pkt.src;
        entry.data = pkt.data;
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign push[l] = take && (pkt.level == LVL_W'(l));
    end
endmodule

// File: rtl/nirq_fifo.sv
module nirq_fifo
    import nirq_pkg::*;
#(
    parameter int DEPTH = 127,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  entry_t           wr_entry,
    input  logic             pop,
    output entry_t           rd_entry,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_entry;
        if (do_pop)  rd_entry    <= mem[rd_ptr];
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CNT_W'(DEPTH))); // R7
    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> (count == $past(count) - 1'b1)); // R6
endmodule

// File: rtl/nirq_rx.sv
module nirq_rx
    import nirq_pkg::*;
#(
    parameter int DEPTH = 127,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  node_id,
    input  logic        pkt_valid,
    input  logic        pkt_cmd,
    input  logic [1:0]  pkt_level,
    input  logic [7:0]  pkt_src,
    input  logic [7:0]  pkt_dst,
    input  logic [31:0] pkt_data,
    input  logic [3:0]  irq_en,
    input  logic        host_rd,
    input  logic [1:0]  host_level,
    input  logic [3:0]  ovf_clr,
    output logic        rd_valid,
    output logic [7:0]  rd_src,
    output logic [31:0] rd_data,
    output logic [3:0]  irq,
    output logic [3:0]  ovf
);
    pkt_t              pkt;
    entry_t            wr_entry;
    logic [LEVELS-1:0] push, pop, empty, full;
    entry_t            q_out [LEVELS];
    logic [CNT_W-1:0]  q_cnt [LEVELS];
    logic [LVL_W-1:0]  rd_lvl_q;

    always_comb begin
        pkt.valid = pkt_valid;
        pkt.cmd   = pkt_cmd;
        pkt.level = pkt_level;
        pkt.src   = pkt_src;
        pkt.dst   = pkt_dst;
        pkt.data  = pkt_data;
    end

    nirq_match u_match (
        .pkt     (pkt),
        .node_id (node_id),
        .push    (push),
        .entry   (wr_entry)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_q
        assign pop[l] = host_rd && (host_level == LVL_W'(l)) && !empty[l];

        nirq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push     (push[l]),
            .wr_entry (wr_entry),
            .pop      (pop[l]),
            .rd_entry (q_out[l]),
            .empty    (empty[l]),
            .full     (full[l]),
            .count    (q_cnt[l])
        );

        assign irq[l] = irq_en[l] && !empty[l];

        always_ff @(posedge clk) begin
            if (rst)                     ovf[l] <= 1'b0;
            else if (push[l] && full[l]) ovf[l] <= 1'b1;
            else if (ovf_clr[l])         ovf[l] <= 1'b0;
        end

        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ovf[l] && !ovf_clr[l]) |=> ovf[l]); // R7
        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
            (!(pkt_valid && pkt_cmd) && !pop[l]) |=> $stable(q_cnt[l])); // R1
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_lvl_q <= '0;
        end else begin
            rd_valid <= |pop;
            if (host_rd) rd_lvl_q <= host_level;
        end
    end

    assign rd_src  = q_out[rd_lvl_q].src;
    assign rd_data = q_out[rd_lvl_q].data;

    AST_RD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(host_rd)); // R6
    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push)); // R4
endmodule

// File: tb/nirq_rx_bench.sv
module nirq_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 127;
    localparam logic [7:0] SELF = 8'h3C;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  node_id;
    logic        pkt_valid, pkt_cmd;
    logic [1:0]  pkt_level;
    logic [7:0]  pkt_src, pkt_dst;
    logic [31:0] pkt_data;
    logic [3:0]  irq_en;
    logic        host_rd;
    logic [1:0]  host_level;
    logic [3:0]  ovf_clr;
    logic        rd_valid;
    logic [7:0]  rd_src;
    logic [31:0] rd_data;
    logic [3:0]  irq, ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nirq_rx #(.DEPTH(DEPTH)) u_nirq_rx (
        .clk(clk), .rst(rst), .node_id(node_id),
        .pkt_valid(pkt_valid), .pkt_cmd(pkt_cmd), .pkt_level(pkt_level),
        .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pkt_data(pkt_data),
        .irq_en(irq_en), .host_rd(host_rd), .host_level(host_level),
        .ovf_clr(ovf_clr), .rd_valid(rd_valid), .rd_src(rd_src),
        .rd_data(rd_data), .irq(irq), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input bit v, input bit c, input logic [1:0] lvl,
                        input logic [7:0] s, input logic [7:0] d, input logic [31:0] w);
        pkt_valid = v; pkt_cmd = c; pkt_level = lvl;
        pkt_src = s; pkt_dst = d; pkt_data = w;
        @(negedge clk);
        pkt_valid = 0; pkt_cmd = 0;
    endtask

    task automatic read(input logic [1:0] lvl, input bit ev, input logic [7:0] es,
                        input logic [31:0] ed, input string req);
        host_rd = 1; host_level = lvl;
        @(negedge clk);
        host_rd = 0;
        check(rd_valid == ev, req, rd_valid, ev);
        if (ev) begin
            check(rd_src == es, req, rd_src, es);
            check(rd_data == ed, req, rd_data, ed);
        end
    endtask

    task automatic t_reset();
        check(irq == 4'h0, "R9", irq, 0);
        check(ovf == 4'h0, "R9", ovf, 0);
        check(rd_valid == 1'b0, "R9", rd_valid, 0);
    endtask

    task automatic t_match();
        send(1, 1, 2'd0, 8'h11, SELF, 32'hA0A0_0001);
        check(irq == 4'b0001, "R2", irq, 4'b0001);
        read(2'd0, 1, 8'h11, 32'hA0A0_0001, "R6");
        check(irq == 4'b0000, "R5", irq, 0);
        read(2'd0, 0, 8'h00, 32'h0, "R6");
    endtask

    task automatic t_reject();
        send(1, 0, 2'd0, 8'h12, SELF, 32'h1);
        check(irq == 4'b0000, "R1", irq, 0);
        send(0, 1, 2'd0, 8'h12, SELF, 32'h2);
        check(irq == 4'b0000, "R1", irq, 0);
        send(1, 1, 2'd0, 8'h12, SELF + 8'h1, 32'h3);
        check(irq == 4'b0000, "R2", irq, 0);
        read(2'd0, 0, 8'h00, 32'h0, "R2");
    endtask

    task automatic t_bcast();
        send(1, 1, 2'd1, 8'h77, 8'hFF, 32'hB00C_0001);
        check(irq == 4'b0010, "R3", irq, 4'b0010);
        read(2'd1, 1, 8'h77, 32'hB00C_0001, "R3");
    endtask

    task automatic t_enable();
        irq_en = 4'b0111;
        send(1, 1, 2'd3, 8'h21, SELF, 32'hE0E0_0003);
        check(irq == 4'b0000, "R5", irq, 0);
        irq_en = 4'b1111;
        #1;
        check(irq == 4'b1000, "R5", irq, 4'b1000);
        read(2'd3, 1, 8'h21, 32'hE0E0_0003, "R5");
    endtask

    task automatic t_levels();
        send(1, 1, 2'd0, 8'h01, SELF, 32'h0000_00A1);
        send(1, 1, 2'd2, 8'h02, 8'hFF, 32'h0000_00B2);
        send(1, 1, 2'd0, 8'h03, SELF, 32'h0000_00C3);
        check(irq == 4'b0101, "R10", irq, 4'b0101);
        read(2'd2, 1, 8'h02, 32'h0000_00B2, "R10");
        read(2'd0, 1, 8'h01, 32'h0000_00A1, "R4");
        read(2'd0, 1, 8'h03, 32'h0000_00C3, "R4");
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++)
            send(1, 1, 2'd2, 8'(i), SELF, 32'h5000_0000 + 32'(i));
        check(ovf == 4'b0000, "R8", ovf, 0);
        send(1, 1, 2'd2, 8'hEE, SELF, 32'hDEAD_BEEF);
        check(ovf == 4'b0100, "R7", ovf, 4'b0100);
        for (int i = 0; i < DEPTH; i++)
            read(2'd2, 1, 8'(i), 32'h5000_0000 + 32'(i), "R8");
        read(2'd2, 0, 8'h00, 32'h0, "R7");
        check(ovf == 4'b0100, "R7", ovf, 4'b0100);
        ovf_clr = 4'b0100;
        @(negedge clk);
        ovf_clr = 4'b0000;
        check(ovf == 4'b0000, "R7", ovf, 0);
    endtask

    initial begin
        rst = 1; node_id = SELF; pkt_valid = 0; pkt_cmd = 0; pkt_level = 0;
        pkt_src = 0; pkt_dst = 0; pkt_data = 0; irq_en = 4'b1111;
        host_rd = 0; host_level = 0; ovf_clr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_match();
        t_reject();
        t_bcast();
        t_enable();
        t_levels();
        t_full();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule